// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and from two external request pins and turns them into one normal interrupt line for the processor. Every source has its own 3-bit priority, an enable bit, a trigger setting and a vector word. When the handler reads the vector register it receives the vector of the best eligible source. That read also records the source's priority as the new running level. A later end-of-interrupt write restores the previous level, so a source can only break into a running handler when its priority is strictly higher.

A separate fast-interrupt output exists beside the normal path. It is driven solely by one dedicated external pin. Configuration, vector read-out, end-of-interrupt and edge clearing all go through a simple single-cycle register bus. Read data is registered and appears one cycle after the read strobe. Inputs are taken as already synchronous to `clk`.

Top module: `pvic_top`

## Requirements
- R1: `fiq_o` equals the value `fiq_i` had one clock earlier, and no peripheral input, external request line or bus access changes it.
- R2: `irq_o` is high one clock after a cycle in which at least one source is pending, enabled and above the running level; peripheral sources are indices 0..N_INT-1 and external lines are indices N_INT and up.
- R3: Priorities run from 0 to 7 with 7 the most urgent, and the vector read returns the eligible source with the largest priority.
- R4: Among eligible sources of equal priority the one with the smallest index wins.
- R5: Writing address 0x20 loads the enable mask (bit n enables source n, all zero after reset); a disabled source never raises `irq_o` nor wins a vector read.
- R6: Writing address 0x00+n configures source n with priority in bits [2:0], bit 3 = 1 for edge and 0 for level, and bit 4 = polarity; for peripheral sources bit 4 is ignored and they are always high-level or rising-edge.
- R7: For external sources bit 4 = 1 selects high level or rising edge and bit 4 = 0 selects low level or falling edge.
- R8: An edge-mode source stays pending after its active edge until its vector is read or a 1 is written to its bit at address 0x23; a level-mode source is pending exactly while its input is active.
- R9: Address 0x10+n holds the vector of source n; a read of address 0x21 returns the winner's vector one clock later and makes its priority the running level, and a write to 0x22 returns to the level below.
- R10: A read of 0x21 with no eligible source returns the spurious vector held at address 0x24 and changes no level.
- R11: After reset `irq_o`, `fiq_o` and `bus_rdata_o` are low, all sources are disabled, level-mode, priority 0 and active-high, and no level is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_irq_i | input | N_INT | Peripheral request lines |
| ext_irq_i | input | N_EXT | External request pins |
| fiq_i | input | 1 | Dedicated fast-interrupt pin, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 6 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A wrong level on the internal stack shows at the ports within two clocks: `irq_o` either stays high after a vector read of a same-level source, or fails to rise for a strictly higher one. A stale or lost edge latch shows as `irq_o` staying high after a clear, or staying low after an edge. A wrong arbitration choice shows on the very next vector word. A reference model in the bench is compared against `irq_o`, `fiq_o` and every vector read on each clock, so any of these faults is caught on the first cycle where the outputs diverge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W = 3;
  localparam int LEVELS = 1 << PRIO_W;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_MASK = 6'h20;
  localparam logic [ADDR_W-1:0] A_IVR  = 6'h21;
  localparam logic [ADDR_W-1:0] A_EOI  = 6'h22;
  localparam logic [ADDR_W-1:0] A_ECLR = 6'h23;
  localparam logic [ADDR_W-1:0] A_SPUR = 6'h24;
endpackage

// File: rtl/pvic_src_cond.sv
module pvic_src_cond (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic edge_mode_i,
  input  logic pol_hi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic norm;
  logic prev_q;
  logic latch_q;

  assign norm = pol_hi_i ? raw_i : ~raw_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= norm;
      if (edge_mode_i && norm && !prev_q) latch_q <= 1'b1;
      else if (clr_i)                     latch_q <= 1'b0;
    end
  end

  assign pend_o = edge_mode_i ? latch_q : norm;
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                         floor_valid_i,
  input  logic [PRIO_W-1:0]            floor_lvl_i,
  output logic                         win_valid_o,
  output logic [SRC_W-1:0]             win_idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!floor_valid_i || prio_i[i] > floor_lvl_i) &&
          (!win_valid_o || prio_i[i] > best)) begin
        win_valid_o = 1'b1;
        best        = prio_i[i];
        win_idx_o   = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_lvl_i,
  input  logic              pop_i,
  output logic              top_valid_o,
  output logic [PRIO_W-1:0] top_lvl_o
);
  logic [LEVELS-1:0] active_q;
  logic [LEVELS-1:0] active_d;

  always_comb begin
    top_valid_o = 1'b0;
    top_lvl_o   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (active_q[l]) begin
        top_valid_o = 1'b1;
        top_lvl_o   = PRIO_W'(l);
      end
    end
  end

  always_comb begin
    active_d = active_q;
    if (pop_i && top_valid_o) active_d[top_lvl_o] = 1'b0;
    if (push_i)               active_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active_d;
  end

  // R9
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !top_valid_o) |=> !top_valid_o);
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int N_INT  = 6,
  parameter int N_EXT  = 2,
  parameter int VEC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_INT-1:0]  per_irq_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              fiq_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int N_SRC = N_INT + N_EXT;
  localparam int SRC_W = $clog2(N_SRC);

  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]             edge_q;
  logic [N_EXT-1:0]             pol_q;
  logic [N_SRC-1:0]             mask_q;
  logic [VEC_W-1:0]             spur_q;
  logic [VEC_W-1:0]             vec_mem [N_SRC];
  logic                         irq_q, fiq_q;
  logic [DATA_W-1:0]            rdata_q;

  logic [N_SRC-1:0] raw, pend, clr;
  logic             win_valid;
  logic [SRC_W-1:0] win_idx;
  logic             top_valid;
  logic [PRIO_W-1:0] top_lvl;
  logic [SRC_W-1:0] sel_idx;
  logic cfg_hit, vec_we, mask_we, spur_we, eclr_we, rd_ivr, eoi_we, stack_push;

  assign raw     = {ext_irq_i, per_irq_i};
  assign sel_idx = bus_addr_i[SRC_W-1:0];
  assign cfg_hit = bus_wr_i && bus_addr_i[ADDR_W-1:4] == '0 && int'(bus_addr_i[3:0]) < N_SRC;
  assign vec_we  = bus_wr_i && bus_addr_i[ADDR_W-1:4] == 2'b01 && int'(bus_addr_i[3:0]) < N_SRC;
  assign mask_we = bus_wr_i && bus_addr_i == A_MASK;
  assign spur_we = bus_wr_i && bus_addr_i == A_SPUR;
  assign eclr_we = bus_wr_i && bus_addr_i == A_ECLR;
  assign eoi_we  = bus_wr_i && bus_addr_i == A_EOI;
  assign rd_ivr  = bus_rd_i && bus_addr_i == A_IVR;
  assign stack_push = rd_ivr && win_valid;

  always_comb begin
    clr = eclr_we ? bus_wdata_i[N_SRC-1:0] : '0;
    if (stack_push) clr[win_idx] = 1'b1;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic pol_hi;
    if (g >= N_INT) begin : g_ext
      assign pol_hi = pol_q[g-N_INT];
    end else begin : g_int
      assign pol_hi = 1'b1;
    end
    pvic_src_cond u_cond (
      .clk(clk), .rst(rst), .raw_i(raw[g]), .edge_mode_i(edge_q[g]),
      .pol_hi_i(pol_hi), .clr_i(clr[g]), .pend_o(pend[g])
    );
  end

  pvic_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .req_i(pend & mask_q), .prio_i(prio_q), .floor_valid_i(top_valid),
    .floor_lvl_i(top_lvl), .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  pvic_level_stack u_stack (
    .clk(clk), .rst(rst), .push_i(stack_push), .push_lvl_i(prio_q[win_idx]),
    .pop_i(eoi_we), .top_valid_o(top_valid), .top_lvl_o(top_lvl)
  );

  always_ff @(posedge clk) begin
    if (vec_we) vec_mem[sel_idx] <= bus_wdata_i[VEC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      edge_q  <= '0;
      pol_q   <= '1;
      mask_q  <= '0;
      spur_q  <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= win_valid;
      fiq_q <= fiq_i;
      if (rd_ivr) rdata_q <= win_valid ? DATA_W'(vec_mem[win_idx]) : DATA_W'(spur_q);
      if (cfg_hit) begin
        prio_q[sel_idx] <= bus_wdata_i[PRIO_W-1:0];
        edge_q[sel_idx] <= bus_wdata_i[PRIO_W];
      end
      for (int j = 0; j < N_EXT; j++)
        if (cfg_hit && int'(sel_idx) == N_INT + j) pol_q[j] <= bus_wdata_i[PRIO_W+1];
      if (mask_we) mask_q <= bus_wdata_i[N_SRC-1:0];
      if (spur_we) spur_q <= bus_wdata_i[VEC_W-1:0];
    end
  end

  assign irq_o       = irq_q;
  assign fiq_o       = fiq_q;
  assign bus_rdata_o = rdata_q;

  // R1
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fiq_o == $past(fiq_i));
  // R5
  grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (mask_q[win_idx] && pend[win_idx]));
  // R9
  push_above_chk: assert property (@(posedge clk) disable iff (rst)
    stack_push |-> (!top_valid || prio_q[win_idx] > top_lvl));
  // R10
  spurious_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ivr && !win_valid) |=> bus_rdata_o == DATA_W'($past(spur_q)));
endmodule

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
  localparam int N_INT = 6, N_EXT = 2, N_SRC = 8;

  logic clk = 0, rst = 1;
  logic [N_INT-1:0] per_irq = '0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic fiq = 0, bwr = 0, brd = 0;
  logic [5:0] baddr = '0;
  logic [15:0] bwdata = '0, brdata;
  logic irq_o, fiq_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pvic_top dut_i (
    .clk(clk), .rst(rst), .per_irq_i(per_irq), .ext_irq_i(ext_irq), .fiq_i(fiq),
    .bus_wr_i(bwr), .bus_rd_i(brd), .bus_addr_i(baddr), .bus_wdata_i(bwdata),
    .bus_rdata_o(brdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // behavioural reference model
  int m_prio[N_SRC], m_vec[N_SRC];
  bit m_edge[N_SRC], m_pol[N_SRC], m_latch[N_SRC], m_prev[N_SRC], m_mask[N_SRC];
  int m_spur, m_rdata, m_stack[$];
  bit m_irq, m_fiq, m_rd_flag;

  always @(posedge clk) begin
    bit nrm[N_SRC];
    bit inb, pnd;
    int cur, best;
    if (rst) begin
      foreach (m_prio[i]) begin
        m_prio[i] = 0; m_edge[i] = 0; m_pol[i] = 1; m_latch[i] = 0; m_prev[i] = 0; m_mask[i] = 0;
      end
      m_spur = 0; m_rdata = 0; m_stack.delete(); m_irq = 0; m_fiq = 0; m_rd_flag = 0;
    end else begin
      cur = (m_stack.size() > 0) ? m_stack[$] : -1;
      best = -1;
      for (int i = 0; i < N_SRC; i++) begin
        inb = (i < N_INT) ? per_irq[i] : ext_irq[i-N_INT];
        nrm[i] = (i < N_INT || m_pol[i]) ? inb : !inb;
        pnd = m_edge[i] ? m_latch[i] : nrm[i];
        if (pnd && m_mask[i] && m_prio[i] > cur && (best < 0 || m_prio[i] > m_prio[best])) best = i;
      end
      m_irq = (best >= 0);
      m_fiq = fiq;
      if (brd && baddr == 6'h21) begin
        m_rdata = (best >= 0) ? m_vec[best] : m_spur;
        m_rd_flag = 1;
        if (best >= 0) m_latch[best] = 0;
      end
      if (bwr && baddr == 6'h23) for (int i = 0; i < N_SRC; i++) if (bwdata[i]) m_latch[i] = 0;
      for (int i = 0; i < N_SRC; i++) begin
        if (m_edge[i] && nrm[i] && !m_prev[i]) m_latch[i] = 1;
        m_prev[i] = nrm[i];
      end
      if (bwr && baddr == 6'h22 && m_stack.size() > 0) void'(m_stack.pop_back());
      if (brd && baddr == 6'h21 && best >= 0) m_stack.push_back(m_prio[best]);
      if (bwr && baddr < N_SRC) begin
        m_prio[baddr] = bwdata[2:0]; m_edge[baddr] = bwdata[3];
        if (baddr >= N_INT) m_pol[baddr] = bwdata[4];
      end
      if (bwr && baddr >= 6'h10 && baddr < 6'h10 + N_SRC) m_vec[baddr-6'h10] = bwdata;
      if (bwr && baddr == 6'h20) for (int i = 0; i < N_SRC; i++) m_mask[i] = bwdata[i];
      if (bwr && baddr == 6'h24) m_spur = bwdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 irq_o vs model", irq_o, m_irq);
      chk("R1 fiq_o vs model", fiq_o, m_fiq);
      if (m_rd_flag) begin
        chk("R9 vector vs model", brdata, m_rdata);
        m_rd_flag = 0;
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [5:0] a, logic [15:0] d);
    bwr = 1; baddr = a; bwdata = d; @(negedge clk); bwr = 0;
  endtask
  task automatic ivr(output int v);
    brd = 1; baddr = 6'h21; @(negedge clk); brd = 0; v = brdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    cyc(3); rst = 0; cyc(1);
    chk("R11 reset irq", irq_o, 0); chk("R11 reset fiq", fiq_o, 0); chk("R11 reset rdata", brdata, 0);
    for (int i = 0; i < N_SRC; i++) wr(6'(6'h10 + i), 16'(16'h0100 + i));
    wr(6'h24, 16'hDEAD);
    ivr(v); chk("R10 spurious", v, 16'hDEAD);
    wr(6'h00, 16'd2); wr(6'h20, 16'h00FF);
    per_irq[0] = 1; cyc(2); chk("R2 irq on level", irq_o, 1);
    ivr(v); chk("R9 vector src0", v, 16'h0100);
    cyc(2); chk("R9 same level blocked", irq_o, 0);
    wr(6'h03, 16'd5); per_irq[3] = 1; cyc(2); chk("R9 preempt higher", irq_o, 1);
    ivr(v); chk("R9 vector src3", v, 16'h0103);
    wr(6'h22, 0); wr(6'h22, 0);
    per_irq[0] = 0; per_irq[3] = 0; cyc(2); chk("R8 level released", irq_o, 0);
    wr(6'h01, 16'd4); wr(6'h02, 16'd4); per_irq[1] = 1; per_irq[2] = 1; cyc(2);
    ivr(v); chk("R4 tie lower index", v, 16'h0101);
    wr(6'h22, 0); per_irq[1] = 0; per_irq[2] = 0;
    wr(6'h04, 16'd6); wr(6'h05, 16'd1); per_irq[4] = 1; per_irq[5] = 1; cyc(2);
    ivr(v); chk("R3 highest priority", v, 16'h0104);
    wr(6'h22, 0); per_irq[4] = 0;
    wr(6'h20, 16'h00DF); cyc(2); chk("R5 masked source", irq_o, 0);
    ivr(v); chk("R5 masked not vectored", v, 16'hDEAD);
    per_irq[5] = 0; wr(6'h20, 16'h00FF);
    wr(6'h01, 16'h000B); per_irq[1] = 1; cyc(3); chk("R6 internal edge ignores pol", irq_o, 1);
    wr(6'h23, 16'h0002); cyc(2); chk("R8 explicit clear", irq_o, 0);
    per_irq[1] = 0; cyc(1); per_irq[1] = 1; cyc(3); chk("R8 edge latched", irq_o, 1);
    ivr(v); chk("R8 vector edge src1", v, 16'h0101);
    wr(6'h22, 0); cyc(2); chk("R8 read clears latch", irq_o, 0);
    per_irq[1] = 0;
    wr(6'h02, 16'h0001); per_irq[2] = 1; cyc(2); chk("R6 internal level ignores pol", irq_o, 1);
    per_irq[2] = 0; cyc(2);
    ext_irq[0] = 1; cyc(2); wr(6'h06, 16'h000A); cyc(2); chk("R7 falling idle", irq_o, 0);
    ext_irq[0] = 0; cyc(3); chk("R7 falling edge", irq_o, 1);
    ivr(v); chk("R7 vector ext0", v, 16'h0106);
    wr(6'h22, 0);
    ext_irq[1] = 1; cyc(2); wr(6'h07, 16'h0003); cyc(2); chk("R7 low level idle", irq_o, 0);
    ext_irq[1] = 0; cyc(2); chk("R7 low level active", irq_o, 1);
    ext_irq[1] = 1; cyc(2); chk("R7 low level released", irq_o, 0);
    fiq = 1; cyc(2); chk("R1 fiq high", fiq_o, 1); chk("R1 fiq no irq", irq_o, 0);
    fiq = 0; per_irq = '1; cyc(2); chk("R1 fiq ignores peripherals", fiq_o, 0);
    per_irq = '0; cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule